// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block maps a 32-bit CPU address onto one of eight programmable address windows. It reports whether the address hits a window, which window won, and that window's target ID and target attribute. It also gives the outbound address, and the first two windows can relocate that address through a remap pair. When no enabled window matches, a miss flag is raised. Software sets up the windows through a one-cycle register write port. Each window has a control word and a base word, and windows 0 and 1 also have remap-low and remap-high words.

Window sizes are thermometer masks in 64 KiB units. A separate combinational helper converts a byte count into such a mask, so that software or a neighbouring block can produce the field. After reset the two highest windows already cover a boot region, so fetches work before any window is programmed.

Top module: `addrwin_decoder`

## Requirements
- R1: There are eight windows, selected by `wr_win` (0..7). `wr_sel` picks the word that a write with `wr_en` high updates: 0 control, 1 base, 2 remap-low, 3 remap-high. A write changes decode only from the next rising clock edge. Decode in the write cycle still uses the old contents.
- R2: The control word is laid out as size mask [31:16], attribute [15:8], target ID [7:1] and enable [0]. Writing zero to it disables the window, and that window then never hits.
- R3: An enabled window hits when `addr[31:16]` equals `base[31:16]` in every bit where the size mask is 0. Address bits 15:0 are not compared. A mask of 0x0000 covers 64 KiB and a mask of 0x00FF covers 16 MiB.
- R4: When several enabled windows hit, the lowest-numbered one wins. Its number appears on `win_idx`, and its target and attribute appear on `tgt_id` and `tgt_attr`.
- R5: When no window hits, `hit` is 0 and `miss` is 1. `tgt_id`, `tgt_attr`, `win_idx` and `out_addr_hi` are 0, and `out_addr_lo` equals `addr`.
- R6: On a hit in window 0 or 1, `out_addr_lo[31:16]` takes `addr` bits where the mask is 1 and remap-low bits where the mask is 0, and `out_addr_hi` equals remap-high. On a hit in any other window, `out_addr_lo` equals `addr` and `out_addr_hi` is 0.
- R7: Writes of remap-low or remap-high to windows 2..7 are ignored.
- R8: After reset, windows 6 and 7 are enabled with base 0xFFF00000, mask 0x000F, target 0x0D and attribute 0x1E. All other words are zero, so windows 0..5 are disabled.
- R9: The base word can be rewritten while its window is disabled. The window does not hit until its control word is written with enable set.
- R10: `size_field` equals ((`size_bytes`-1)>>16) with every set bit propagated toward bit 0 over bits 15..0. A byte count of 0 gives 0xFFFF (4 GiB).
- R11: `out_addr_lo[15:0]` always equals `addr[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window selected by the write |
| wr_sel | input | 2 | Word selected by the write (0 ctrl, 1 base, 2 remap-low, 3 remap-high) |
| wr_data | input | 32 | Write data |
| addr | input | 32 | CPU address to decode |
| hit | output | 1 | Some enabled window matches |
| miss | output | 1 | No enabled window matches |
| win_idx | output | 3 | Winning window number |
| tgt_id | output | 7 | Target ID of the winning window |
| tgt_attr | output | 8 | Target attribute of the winning window |
| out_addr_lo | output | 32 | Translated outbound address, low word |
| out_addr_hi | output | 32 | Outbound address, high word |
| size_bytes | input | 32 | Byte count for the size helper |
| size_field | output | 16 | Size mask computed from `size_bytes` |

## Verification
A register write and a decode can fall in the same cycle. In that case the decode must still use the old window setup until the clock edge. The bench provokes this by driving an enabling control write together with an address that only the new setup would hit. It checks for a miss before the edge and for a hit on that window after it. The bench also lets a prioritised decode meet overlapping windows: two enabled windows cover the same address, and the bench checks that the lower number wins in the overlap and the larger window wins outside it.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;

    typedef struct packed {
        logic [15:0] size;
        logic [7:0]  attr;
        logic [6:0]  tgt;
        logic        en;
    } win_ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RLO  = 2'd2,
        SEL_RHI  = 2'd3
    } reg_sel_e;

    function automatic logic [15:0] bytes_to_size(input logic [31:0] nbytes);
        logic [31:0] v;
        v = (nbytes - 32'd1) >> 16;
        v = v | (v >> 1);
        v = v | (v >> 2);
        v = v | (v >> 4);
        v = v | (v >> 8);
        return v[15:0];
    endfunction

endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
    import addrwin_pkg::*;
#(
    parameter int          NUM_WIN    = 8,
    parameter int          NUM_REMAP  = 2,
    parameter int          BOOT_FIRST = 6,
    parameter logic [31:0] BOOT_BASE  = 32'hFFF0_0000,
    parameter logic [15:0] BOOT_SIZE  = 16'h000F,
    parameter logic [6:0]  BOOT_TGT   = 7'h0D,
    parameter logic [7:0]  BOOT_ATTR  = 8'h1E,
    localparam int         IDX_W      = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_win,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    output win_ctrl_t        ctrl_o [NUM_WIN],
    output logic [15:0]      base_o [NUM_WIN],
    output logic [15:0]      rlo_o  [NUM_REMAP],
    output logic [31:0]      rhi_o  [NUM_REMAP]
);

    localparam win_ctrl_t BOOT_CTRL = '{size: BOOT_SIZE, attr: BOOT_ATTR,
                                        tgt: BOOT_TGT, en: 1'b1};

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_o[i] <= (i >= BOOT_FIRST) ? BOOT_CTRL : '0;
                base_o[i] <= (i >= BOOT_FIRST) ? BOOT_BASE[31:16] : '0;
            end else if (wr_en && wr_win == IDX_W'(i)) begin
                if (sel == SEL_CTRL) ctrl_o[i] <= win_ctrl_t'(wr_data);
                if (sel == SEL_BASE) base_o[i] <= wr_data[31:16];
            end
        end
    end

    for (genvar r = 0; r < NUM_REMAP; r++) begin : g_remap
        always_ff @(posedge clk) begin
            if (rst) begin
                rlo_o[r] <= '0;
                rhi_o[r] <= '0;
            end else if (wr_en && wr_win == IDX_W'(r)) begin
                if (sel == SEL_RLO) rlo_o[r] <= wr_data[31:16];
                if (sel == SEL_RHI) rhi_o[r] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  win_ctrl_t          ctrl_i [NUM_WIN],
    input  logic [15:0]        base_i [NUM_WIN],
    input  logic [15:0]        addr_hi_i,
    output logic [NUM_WIN-1:0] hit_vec_o
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        logic [15:0] diff;
        assign diff         = (addr_hi_i ^ base_i[i]) & ~ctrl_i[i].size;
        assign hit_vec_o[i] = ctrl_i[i].en && (diff == 16'h0000);
    end

endmodule

// File: rtl/addrwin_select.sv
module addrwin_select
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hit_vec_i,
    input  win_ctrl_t          ctrl_i [NUM_WIN],
    input  logic [15:0]        rlo_i  [NUM_REMAP],
    input  logic [31:0]        rhi_i  [NUM_REMAP],
    input  logic [31:0]        addr_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [6:0]         tgt_o,
    output logic [7:0]         attr_o,
    output logic [31:0]        out_lo_o,
    output logic [31:0]        out_hi_o
);

    win_ctrl_t win_sel;

    always_comb begin
        idx_o = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o   = |hit_vec_i;
    assign win_sel = ctrl_i[idx_o];
    assign tgt_o   = hit_o ? win_sel.tgt  : '0;
    assign attr_o  = hit_o ? win_sel.attr : '0;

    always_comb begin
        out_lo_o = addr_i;
        out_hi_o = '0;
        for (int r = 0; r < NUM_REMAP; r++) begin
            if (hit_o && idx_o == IDX_W'(r)) begin
                out_lo_o = {(addr_i[31:16] & win_sel.size) | (rlo_i[r] & ~win_sel.size),
                            addr_i[15:0]};
                out_hi_o = rhi_i[r];
            end
        end
    end

endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
    import addrwin_pkg::*;
#(
    parameter int          NUM_WIN    = 8,
    parameter int          NUM_REMAP  = 2,
    parameter int          BOOT_FIRST = 6,
    parameter logic [31:0] BOOT_BASE  = 32'hFFF0_0000,
    parameter logic [15:0] BOOT_SIZE  = 16'h000F,
    parameter logic [6:0]  BOOT_TGT   = 7'h0D,
    parameter logic [7:0]  BOOT_ATTR  = 8'h1E,
    localparam int         IDX_W      = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_win,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      addr,
    output logic             hit,
    output logic             miss,
    output logic [IDX_W-1:0] win_idx,
    output logic [6:0]       tgt_id,
    output logic [7:0]       tgt_attr,
    output logic [31:0]      out_addr_lo,
    output logic [31:0]      out_addr_hi,
    input  logic [31:0]      size_bytes,
    output logic [15:0]      size_field
);

    win_ctrl_t          ctrl [NUM_WIN];
    logic [15:0]        base [NUM_WIN];
    logic [15:0]        rlo  [NUM_REMAP];
    logic [31:0]        rhi  [NUM_REMAP];
    logic [NUM_WIN-1:0] hit_vec;

    addrwin_regs #(
        .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .BOOT_FIRST(BOOT_FIRST),
        .BOOT_BASE(BOOT_BASE), .BOOT_SIZE(BOOT_SIZE),
        .BOOT_TGT(BOOT_TGT), .BOOT_ATTR(BOOT_ATTR)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_o(ctrl), .base_o(base), .rlo_o(rlo), .rhi_o(rhi)
    );

    addrwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .ctrl_i(ctrl), .base_i(base), .addr_hi_i(addr[31:16]),
        .hit_vec_o(hit_vec)
    );

    addrwin_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_sel (
        .hit_vec_i(hit_vec), .ctrl_i(ctrl), .rlo_i(rlo), .rhi_i(rhi),
        .addr_i(addr), .hit_o(hit), .idx_o(win_idx), .tgt_o(tgt_id),
        .attr_o(tgt_attr), .out_lo_o(out_addr_lo), .out_hi_o(out_addr_hi)
    );

    assign miss       = ~hit;
    assign size_field = bytes_to_size(size_bytes);

endmodule

// File: rtl/addrwin_chk.sv
module addrwin_chk #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_win,
    input logic [1:0]       wr_sel,
    input logic [31:0]      wr_data,
    input logic [31:0]      addr,
    input logic             hit,
    input logic             miss,
    input logic [IDX_W-1:0] win_idx,
    input logic [6:0]       tgt_id,
    input logic [7:0]       tgt_attr,
    input logic [31:0]      out_addr_lo,
    input logic [31:0]      out_addr_hi,
    input logic [31:0]      size_bytes,
    input logic [15:0]      size_field
);

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        hit != miss);                                               // R5

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        miss |-> (tgt_id == '0 && tgt_attr == '0 && win_idx == '0
                  && out_addr_hi == '0 && out_addr_lo == addr));    // R5

    AST_CTRL_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && wr_data == 32'h0)
        |=> !(hit && win_idx == $past(wr_win)));                    // R2

    AST_HI_ONLY_REMAP: assert property (@(posedge clk) disable iff (rst)
        (out_addr_hi != '0) |-> (hit && int'(win_idx) < NUM_REMAP)); // R6

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        out_addr_lo[15:0] == addr[15:0]);                           // R11

    AST_SIZE_THERMO: assert property (@(posedge clk) disable iff (rst)
        (size_field & (size_field + 16'd1)) == 16'h0);              // R10

    AST_SIZE_ZERO_FULL: assert property (@(posedge clk) disable iff (rst)
        (size_bytes == 32'h0) |-> (size_field == 16'hFFFF));        // R10

endmodule

bind addrwin_decoder addrwin_chk #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_chk (.*);

// File: tb/tb_addrwin_decoder.sv
module tb_addrwin_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_win;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] addr;
    logic        hit, miss;
    logic [2:0]  win_idx;
    logic [6:0]  tgt_id;
    logic [7:0]  tgt_attr;
    logic [31:0] out_addr_lo, out_addr_hi;
    logic [31:0] size_bytes;
    logic [15:0] size_field;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    addrwin_decoder dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
        .wr_data(wr_data), .addr(addr), .hit(hit), .miss(miss),
        .win_idx(win_idx), .tgt_id(tgt_id), .tgt_attr(tgt_attr),
        .out_addr_lo(out_addr_lo), .out_addr_hi(out_addr_hi),
        .size_bytes(size_bytes), .size_field(size_field)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_win = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a);
        addr = a;
        #2;
    endtask

    task automatic expect_hit(input string req, input logic [2:0] w, input logic [6:0] t,
                              input logic [7:0] at, input logic [31:0] lo, input logic [31:0] hi);
        check({req, " hit"},  {63'h0, hit}, 64'h1);
        check({req, " idx"},  {61'h0, win_idx}, {61'h0, w});
        check({req, " tgt"},  {57'h0, tgt_id}, {57'h0, t});
        check({req, " attr"}, {56'h0, tgt_attr}, {56'h0, at});
        check({req, " out"},  {out_addr_hi, out_addr_lo}, {hi, lo});
    endtask

    task automatic expect_miss(input string req);
        check({req, " miss"}, {62'h0, hit, miss}, 64'h1);
        check({req, " quiet"}, {50'h0, tgt_id, win_idx, tgt_attr[3:0]}, 64'h0);
        check({req, " out"}, {out_addr_hi, out_addr_lo}, {32'h0, addr});
    endtask

    task automatic t_reset;
        probe(32'hFFF0_1234);
        expect_hit("R8 boot win6", 3'd6, 7'h0D, 8'h1E, 32'hFFF0_1234, 32'h0);
        probe(32'hFFFF_FFFF);
        expect_hit("R8 boot top", 3'd6, 7'h0D, 8'h1E, 32'hFFFF_FFFF, 32'h0);
        probe(32'h1234_5678);
        expect_miss("R5 R8 other windows off");
    endtask

    task automatic t_size;
        wr(3'd4, 2'd0, 32'h0);
        wr(3'd4, 2'd1, 32'h2000_0000);
        wr(3'd4, 2'd0, 32'h00FF_330B);
        probe(32'h20FF_ABCD);
        expect_hit("R3 16MiB inside", 3'd4, 7'h05, 8'h33, 32'h20FF_ABCD, 32'h0);
        probe(32'h2100_0000);
        expect_miss("R3 16MiB above");
        probe(32'h1FFF_FFFF);
        expect_miss("R3 16MiB below");
        wr(3'd3, 2'd1, 32'h3000_0000);
        wr(3'd3, 2'd0, 32'h0000_0105);
        probe(32'h3000_FFFF);
        expect_hit("R3 64KiB top", 3'd3, 7'h02, 8'h01, 32'h3000_FFFF, 32'h0);
        probe(32'h3001_0000);
        expect_miss("R3 64KiB next");
    endtask

    task automatic t_priority;
        wr(3'd2, 2'd1, 32'h2000_0000);
        wr(3'd2, 2'd0, 32'h000F_440F);
        probe(32'h2001_2345);
        expect_hit("R4 overlap low wins", 3'd2, 7'h07, 8'h44, 32'h2001_2345, 32'h0);
        probe(32'h2050_0000);
        expect_hit("R4 outside small", 3'd4, 7'h05, 8'h33, 32'h2050_0000, 32'h0);
    endtask

    task automatic t_remap;
        wr(3'd0, 2'd0, 32'h0);
        wr(3'd0, 2'd1, 32'h8000_0000);
        wr(3'd0, 2'd2, 32'h4000_0000);
        wr(3'd0, 2'd3, 32'h0000_0001);
        wr(3'd0, 2'd0, 32'h0FFF_0A13);
        probe(32'h8123_4567);
        expect_hit("R6 R11 remap", 3'd0, 7'h09, 8'h0A, 32'h4123_4567, 32'h1);
        wr(3'd4, 2'd2, 32'hAAAA_0000);
        wr(3'd4, 2'd3, 32'h0000_0055);
        probe(32'h2050_1111);
        expect_hit("R7 R6 no remap win4", 3'd4, 7'h05, 8'h33, 32'h2050_1111, 32'h0);
    endtask

    task automatic t_disable;
        wr(3'd1, 2'd0, 32'h0);
        wr(3'd1, 2'd1, 32'h9000_0000);
        probe(32'h9000_0000);
        expect_miss("R9 base while disabled");
        wr(3'd1, 2'd2, 32'h9000_0000);
        probe(32'h9000_0000);
        expect_miss("R9 still disabled");
        wr(3'd1, 2'd0, 32'h0000_0007);
        probe(32'h9000_1111);
        expect_hit("R9 enabled", 3'd1, 7'h03, 8'h00, 32'h9000_1111, 32'h0);
        wr(3'd3, 2'd0, 32'h0);
        probe(32'h3000_FFFF);
        expect_miss("R2 zero ctrl disables");
        wr(3'd6, 2'd0, 32'h0);
        probe(32'hFFF0_1234);
        expect_hit("R2 win7 after win6 off", 3'd7, 7'h0D, 8'h1E, 32'hFFF0_1234, 32'h0);
    endtask

    task automatic t_same_cycle;
        wr(3'd5, 2'd1, 32'h5000_0000);
        @(negedge clk);
        addr = 32'h5000_0042;
        wr_en = 1'b1; wr_win = 3'd5; wr_sel = 2'd0; wr_data = 32'h0000_5A23;
        #2;
        expect_miss("R1 old setup before edge");
        @(posedge clk);
        #1 wr_en = 1'b0;
        #2;
        expect_hit("R1 new setup after edge", 3'd5, 7'h11, 8'h5A, 32'h5000_0042, 32'h0);
    endtask

    task automatic t_helper;
        size_bytes = 32'h0;        #2 check("R10 zero is 4GiB", {48'h0, size_field}, 64'hFFFF);
        size_bytes = 32'h1;        #2 check("R10 one byte", {48'h0, size_field}, 64'h0);
        size_bytes = 32'h1_0000;   #2 check("R10 64KiB", {48'h0, size_field}, 64'h0);
        size_bytes = 32'h1_0001;   #2 check("R10 round up", {48'h0, size_field}, 64'h1);
        size_bytes = 32'h3_0000;   #2 check("R10 192KiB", {48'h0, size_field}, 64'h3);
        size_bytes = 32'h5_0000;   #2 check("R10 320KiB", {48'h0, size_field}, 64'h7);
        size_bytes = 32'h100_0000; #2 check("R10 16MiB", {48'h0, size_field}, 64'hFF);
        size_bytes = 32'h8000_0001; #2 check("R10 over 2GiB", {48'h0, size_field}, 64'hFFFF);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_win = '0; wr_sel = '0; wr_data = '0;
        addr = '0; size_bytes = 32'h1_0000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_size();
        t_priority();
        t_remap();
        t_disable();
        t_same_cycle();
        t_helper();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule